// File: doc/BRIEF.md
# Two-Channel Display Fetch Sequencer

This block fetches frame data for a display controller on two independent channels. Software hands each channel a descriptor through a descriptor port. The descriptor carries a 32-bit command word and a start address. The command word is kept as a read-only copy per channel, so it can be observed but never written directly. It decides four things: how many bytes to fetch, whether the leading part of the data goes to the palette RAM instead of the pixel stream, and whether start-of-frame and end-of-frame status flags are raised.

Words come from a single memory read port. The engine presents an address and a channel on `mem_addr`/`mem_chan` and holds `mem_rready` high when it can take a word. The memory supplies the word for that same address on `mem_rdata` together with `mem_rvalid`. A word moves only in a cycle where both are high. Pixel words leave on a valid/ready stream. While `pix_ready` is low, `mem_rready` stays low for a pixel word, so back-pressure reaches memory in the same cycle. Palette words are written unconditionally on `pal_we`. The descriptor port is valid/ready too: `desc_ready` is high only while the addressed channel is idle.

A descriptor that is illegal raises a sticky error flag and leaves its channel idle without fetching. Illegal means a zero length, length bits 1:0 not zero, or the palette flag on channel 1. All status flags are sticky and are cleared by writing ones to `stat_clr`.

Top module: `dfs_seq`

## Requirements
- R1: After reset, both command registers and all status bits read zero, `pix_valid`, `pal_we` and `mem_rready` are low, and `desc_ready` is high.
- R2: When a descriptor is accepted, the addressed channel's command register takes bit 26 (palette), bit 22 (start-of-frame enable), bit 21 (end-of-frame enable) and bits 20:0 (byte length) from `desc_cmd`. All other bits read zero, and the register changes at no other time.
- R3: `desc_ready` is low while the channel selected by `desc_chan` is fetching. A descriptor offered then is not taken, and that channel's command register is unchanged.
- R4: A legal descriptor of length L bytes delivers exactly L/4 words, read from the start address and then from each following address in steps of 4. The channel then becomes idle.
- R5: With the palette flag on channel 0, the first min(P, L) bytes are written to the palette port at word index 0, 1, 2 and so on, before any pixel word. P is 8, 8, 32 or 512 for `pix_depth` 0, 1, 2 or 3, and `pix_depth` is sampled only when the descriptor is accepted.
- R6: The start-of-frame bit of a channel (`stat` bit 0 for channel 0, bit 1 for channel 1) is set in the cycle after a legal descriptor with bit 22 set is accepted.
- R7: The end-of-frame bit of a channel (`stat` bit 2 or 3) is set in the cycle after the last word of a transfer is taken, if that descriptor had bit 21 set. Otherwise it stays clear.
- R8: A descriptor whose length is zero, whose length bits 1:0 are not zero, or which sets the palette flag on channel 1, sets the channel's error bit (`stat` bit 4 or 5). It fetches nothing, sets no start-of-frame bit and leaves the channel idle.
- R9: While a pixel word is offered and `pix_ready` is low, `mem_rready` is low. Palette words are taken regardless of `pix_ready`.
- R10: While channel 0 is fetching, every word taken belongs to channel 0. Channel 1 is served only when channel 0 is idle.
- R11: Status bits stay set until a one is written to the same bit of `stat_clr`. A set and a clear in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_depth | input | 2 | Pixel depth code 0..3 = 1, 2, 4, 8 bits per pixel |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Addressed channel is idle and takes the descriptor |
| desc_chan | input | CW | Channel the descriptor is for |
| desc_cmd | input | 32 | Command word of the descriptor |
| desc_addr | input | AW | Start byte address of the data |
| mem_addr | output | AW | Address of the word wanted |
| mem_chan | output | CW | Channel the wanted word belongs to |
| mem_rvalid | input | 1 | Memory offers the word for `mem_addr` |
| mem_rready | output | 1 | Engine takes the word this cycle |
| mem_rdata | input | 32 | Word for `mem_addr` |
| pix_valid | output | 1 | Pixel word offered |
| pix_ready | input | 1 | Pixel sink accepts |
| pix_data | output | 32 | Pixel word |
| pix_chan | output | CW | Channel of the pixel word |
| pal_we | output | 1 | Palette RAM write strobe |
| pal_idx | output | 7 | Palette RAM word index |
| pal_data | output | 32 | Palette RAM write data |
| stat | output | 3*NCH | Sticky flags: start-of-frame, end-of-frame, error per channel |
| stat_clr | input | 3*NCH | Write-one-to-clear for `stat` |
| cmd_regs | output | 32*NCH | Read-only command registers, channel 0 in the low word |

## Verification
A wrong byte counter shows up right away: the pixel or palette stream carries a word from an address that was not expected, or the channel goes idle too early or too late, so the word total and the end-of-frame bit are off when the transfer ends. A bad palette split moves the change from palette writes to pixel words. That is visible on the first word after the boundary and in the palette index sequence. Faults in the arbiter or the back-pressure path show in the order of channel tags and in `mem_rready` during a stalled cycle. Decode faults show in the error and start-of-frame bits one cycle after the descriptor is taken.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int CMD_W   = 32;
  localparam int LEN_W   = 21;
  localparam int PAL_BIT = 26;
  localparam int SOF_BIT = 22;
  localparam int EOF_BIT = 21;
  localparam int PIDX_W  = 7;   // 512 bytes of palette = 128 words
  localparam int PCNT_W  = 8;   // holds a palette word count up to 128

  typedef struct packed {
    logic             pal;
    logic             sof_en;
    logic             eof_en;
    logic [LEN_W-1:0] len;
  } cmd_t;

  function automatic cmd_t cmd_unpack(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.pal    = w[PAL_BIT];
    c.sof_en = w[SOF_BIT];
    c.eof_en = w[EOF_BIT];
    c.len    = w[LEN_W-1:0];
    return c;
  endfunction

  function automatic logic [CMD_W-1:0] cmd_pack(input cmd_t c);
    logic [CMD_W-1:0] w;
    w            = '0;
    w[PAL_BIT]   = c.pal;
    w[SOF_BIT]   = c.sof_en;
    w[EOF_BIT]   = c.eof_en;
    w[LEN_W-1:0] = c.len;
    return w;
  endfunction

  // palette words = min(bytes for this depth, length) / 4
  function automatic logic [PCNT_W-1:0] pal_word_cnt(input logic [1:0] depth,
                                                     input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] pb;
    pb = (depth == 2'd3) ? LEN_W'(512) : (depth == 2'd2) ? LEN_W'(32) : LEN_W'(8);
    if (len < pb) pb = len;
    return pb[PCNT_W+1:2];
  endfunction
endpackage

// File: rtl/dfs_desc_chk.sv
module dfs_desc_chk
  import dfs_pkg::*;
(
  input  logic [LEN_W-1:0] len,
  input  logic             pal,
  input  logic             pal_ok,
  output logic             bad
);
  always_comb begin
    bad = (len == '0) || (len[1:0] != 2'b00) || (pal && !pal_ok);
  end
endmodule

// File: rtl/dfs_arb.sv
module dfs_arb #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  // lowest index wins
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/dfs_chan.sv
module dfs_chan
  import dfs_pkg::*;
#(
  parameter int AW     = 32,
  parameter bit PAL_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  len,
  input  logic              eof_en_in,
  input  logic [AW-1:0]     base,
  input  logic [PCNT_W-1:0] pwords,
  input  logic              take,
  output logic              busy,
  output logic [AW-1:0]     addr,
  output logic              to_pal,
  output logic [PIDX_W-1:0] pidx,
  output logic              last,
  output logic              eof_en
);
  logic              busy_q;
  logic [AW-1:0]     addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [PCNT_W-1:0] palrem_q;
  logic [PIDX_W-1:0] pidx_q;
  logic              eofen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
      palrem_q <= '0;
      pidx_q   <= '0;
      eofen_q  <= 1'b0;
    end else if (load) begin
      busy_q   <= 1'b1;
      addr_q   <= base;
      rem_q    <= len;
      palrem_q <= PAL_OK ? pwords : '0;
      pidx_q   <= '0;
      eofen_q  <= eof_en_in;
    end else if (take) begin
      addr_q <= addr_q + AW'(4);
      rem_q  <= rem_q - LEN_W'(4);
      if (rem_q == LEN_W'(4)) busy_q <= 1'b0;
      if (palrem_q != '0) begin
        palrem_q <= palrem_q - PCNT_W'(1);
        pidx_q   <= pidx_q + PIDX_W'(1);
      end
    end
  end

  assign busy   = busy_q;
  assign addr   = addr_q;
  assign to_pal = busy_q && (palrem_q != '0);
  assign pidx   = pidx_q;
  assign last   = (rem_q == LEN_W'(4));
  assign eof_en = eofen_q;

  // R4
  take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (busy_q && rem_q >= LEN_W'(4)));
  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));
  // R3
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/dfs_seq.sv
module dfs_seq
  import dfs_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 32,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           pix_depth,
  input  logic                 desc_valid,
  output logic                 desc_ready,
  input  logic [CW-1:0]        desc_chan,
  input  logic [CMD_W-1:0]     desc_cmd,
  input  logic [AW-1:0]        desc_addr,
  output logic [AW-1:0]        mem_addr,
  output logic [CW-1:0]        mem_chan,
  input  logic                 mem_rvalid,
  output logic                 mem_rready,
  input  logic [31:0]          mem_rdata,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic [31:0]          pix_data,
  output logic [CW-1:0]        pix_chan,
  output logic                 pal_we,
  output logic [PIDX_W-1:0]    pal_idx,
  output logic [31:0]          pal_data,
  output logic [3*NCH-1:0]     stat,
  input  logic [3*NCH-1:0]     stat_clr,
  output logic [NCH*CMD_W-1:0] cmd_regs
);
  localparam int PAL_CH = 0;

  cmd_t              dcmd;
  logic              accept, bad, pal_ok;
  logic [PCNT_W-1:0] pwords;
  logic [NCH-1:0]    ch_busy, ch_topal, ch_last, ch_eofen, ch_load, ch_take;
  logic [AW-1:0]     ch_addr [NCH];
  logic [PIDX_W-1:0] ch_pidx [NCH];
  logic [CMD_W-1:0]  cmd_q   [NCH];
  logic [CW-1:0]     gidx;
  logic              gany, g_topal, take;
  logic [NCH-1:0]    set_sof, set_eof, set_err;
  logic [3*NCH-1:0]  stat_q;

  assign dcmd       = cmd_unpack(desc_cmd);
  assign pal_ok     = (desc_chan == CW'(PAL_CH));
  assign desc_ready = !ch_busy[desc_chan];
  assign accept     = desc_valid && desc_ready;
  assign pwords     = dcmd.pal ? pal_word_cnt(pix_depth, dcmd.len) : '0;

  dfs_desc_chk u_chk (
    .len(dcmd.len), .pal(dcmd.pal), .pal_ok(pal_ok), .bad(bad)
  );

  dfs_arb #(.N(NCH), .IW(CW)) u_arb (
    .req(ch_busy), .idx(gidx), .any(gany)
  );

  // shared read port goes to the granted channel
  assign g_topal    = ch_topal[gidx];
  assign mem_addr   = ch_addr[gidx];
  assign mem_chan   = gidx;
  assign mem_rready = gany && (g_topal || pix_ready);
  assign take       = mem_rvalid && mem_rready;
  assign pix_valid  = mem_rvalid && gany && !g_topal;
  assign pix_data   = mem_rdata;
  assign pix_chan   = gidx;
  assign pal_we     = mem_rvalid && gany && g_topal;
  assign pal_idx    = ch_pidx[gidx];
  assign pal_data   = mem_rdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_load[c] = accept && !bad && (desc_chan == CW'(c));
    assign ch_take[c] = take && (gidx == CW'(c));

    dfs_chan #(.AW(AW), .PAL_OK(c == PAL_CH)) u_chan (
      .clk(clk), .rst_n(rst_n), .load(ch_load[c]), .len(dcmd.len),
      .eof_en_in(dcmd.eof_en), .base(desc_addr), .pwords(pwords),
      .take(ch_take[c]), .busy(ch_busy[c]), .addr(ch_addr[c]),
      .to_pal(ch_topal[c]), .pidx(ch_pidx[c]), .last(ch_last[c]),
      .eof_en(ch_eofen[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) cmd_q[c] <= '0;
      else if (accept && desc_chan == CW'(c)) cmd_q[c] <= cmd_pack(dcmd);
    end
    assign cmd_regs[c*CMD_W +: CMD_W] = cmd_q[c];

    assign set_sof[c] = ch_load[c] && dcmd.sof_en;
    assign set_eof[c] = ch_take[c] && ch_last[c] && ch_eofen[c];
    assign set_err[c] = accept && bad && (desc_chan == CW'(c));

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && desc_chan == CW'(c)) |=> $stable(cmd_q[c]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | {set_err, set_eof, set_sof};
  end
  assign stat = stat_q;

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |-> !mem_rready);
  // R10
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_busy[0] && mem_rready) |-> (mem_chan == CW'(0)));
  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad) |=> (stat_q[2*NCH +: NCH] != '0));
  // R6
  sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load != '0 && dcmd.sof_en) |=> (stat_q[NCH-1:0] != '0));
endmodule

// File: tb/dfs_seq_bench.sv
module dfs_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pix_depth = 2'd0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [0:0]  desc_chan = 1'b0;
  logic [31:0] desc_cmd = '0;
  logic [31:0] desc_addr = '0;
  logic [31:0] mem_addr;
  logic [0:0]  mem_chan;
  logic        mem_rvalid = 1'b0;
  logic        mem_rready;
  logic [31:0] mem_rdata;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [31:0] pix_data;
  logic [0:0]  pix_chan;
  logic        pal_we;
  logic [6:0]  pal_idx;
  logic [31:0] pal_data;
  logic [5:0]  stat;
  logic [5:0]  stat_clr = '0;
  logic [63:0] cmd_regs;

  dfs_seq u_dfs_seq (
    .clk(clk), .rst_n(rst_n), .pix_depth(pix_depth), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_chan(desc_chan), .desc_cmd(desc_cmd),
    .desc_addr(desc_addr), .mem_addr(mem_addr), .mem_chan(mem_chan),
    .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pix_chan(pix_chan), .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
    .stat(stat), .stat_clr(stat_clr), .cmd_regs(cmd_regs)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction
  assign mem_rdata = memf(mem_addr);

  // handshake driver
  logic        hs_rand = 1'b0, fix_rv = 1'b0, fix_pr = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_rvalid <= hs_rand ? (lfsr[0] | lfsr[3]) : fix_rv;
    pix_ready  <= hs_rand ? (lfsr[1] | lfsr[6]) : fix_pr;
  end

  // expectations (written by the test process only)
  logic [31:0] base_e [2];
  int          words_e [2], palw_e [2], snap_pal [2], snap_pix [2];
  // monitor state (written by the monitor only)
  int          mon_pal [2], mon_pix [2];
  int          seq_log [16];
  int          mon_checks = 0, mon_errors = 0;
  int          checks = 0, errors = 0;

  initial begin
    for (int i = 0; i < 2; i++) begin
      mon_pal[i] = 0; mon_pix[i] = 0; base_e[i] = '0;
      words_e[i] = 0; palw_e[i] = 0; snap_pal[i] = 0; snap_pix[i] = 0;
    end
    for (int i = 0; i < 16; i++) seq_log[i] = 0;
  end

  task automatic mchk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
    mon_checks++;
    if (act !== exp) begin
      mon_errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor samples 2 ns before the rising edge
  always begin
    int n, c;
    @(negedge clk); #8;
    if (rst_n) begin
      if (pal_we) begin
        n = (mon_pal[0] - snap_pal[0]) + (mon_pix[0] - snap_pix[0]);
        mchk("R5", "palette index", 32'(pal_idx), 32'(mon_pal[0] - snap_pal[0]));
        mchk("R5", "palette data", pal_data, memf(base_e[0] + 32'(4 * n)));
        mon_pal[0]++;
      end
      if (pix_valid && !pix_ready) mchk("R9", "rready while stalled", 32'(mem_rready), 0);
      if (pix_valid && pix_ready) begin
        c = int'(pix_chan);
        n = (mon_pal[c] - snap_pal[c]) + (mon_pix[c] - snap_pix[c]);
        mchk("R4", "pixel data", pix_data, memf(base_e[c] + 32'(4 * n)));
        mchk("R5", "palette words before pixel", 32'(mon_pal[c] - snap_pal[c]), 32'(palw_e[c]));
        seq_log[(mon_pix[0] + mon_pix[1]) & 15] = c;
        mon_pix[c]++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks + 1, errors + mon_errors + 1);
    $finish;
  end

  task automatic set_exp(input int c, input logic [31:0] b, input int len, input int palw);
    base_e[c]   = b;
    words_e[c]  = len / 4;
    palw_e[c]   = palw;
    snap_pal[c] = mon_pal[c];
    snap_pix[c] = mon_pix[c];
  endtask

  // offer a descriptor until taken; returns at the negedge after acceptance
  task automatic send_desc(input int c, input logic [31:0] cmd, input logic [31:0] b);
    @(negedge clk);
    desc_valid = 1'b1; desc_chan = 1'(c); desc_cmd = cmd; desc_addr = b;
    for (int i = 0; i < 5000; i++) begin
      #8;
      if (desc_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic wait_done(input int c);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #9;
      if ((mon_pal[c] - snap_pal[c]) + (mon_pix[c] - snap_pix[c]) >= words_e[c]) break;
    end
    @(negedge clk); #9;
    chk("R4", "pixel word count", 32'(mon_pix[c] - snap_pix[c]), 32'(words_e[c] - palw_e[c]));
    chk("R5", "palette word count", 32'(mon_pal[c] - snap_pal[c]), 32'(palw_e[c]));
    desc_chan = 1'(c);
    #1;
    chk("R4", "channel idle after transfer", 32'(desc_ready), 32'd1);
  endtask

  task automatic clear_stat();
    @(negedge clk); stat_clr = '1;
    @(negedge clk); stat_clr = '0;
  endtask

  function automatic logic [31:0] mk_cmd(input bit pal, input bit sof, input bit eof,
                                         input int len);
    return (32'(pal) << 26) | (32'(sof) << 22) | (32'(eof) << 21) | (32'(len) & 32'h1F_FFFF);
  endfunction

  localparam logic [31:0] JUNK = 32'hF800_0000 | (32'h1 << 25) | (32'h1 << 23);

  initial begin
    int lens [4];
    int chl [3];
    logic [31:0] prev;
    lens[0] = 4; lens[1] = 8; lens[2] = 36; lens[3] = 520;
    chl[0] = 4; chl[1] = 12; chl[2] = 64;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #9;
    // R1 reset state
    chk("R1", "status", 32'(stat), 0);
    chk("R1", "command registers low", cmd_regs[31:0], 0);
    chk("R1", "command registers high", cmd_regs[63:32], 0);
    chk("R1", "pix_valid", 32'(pix_valid), 0);
    chk("R1", "pal_we", 32'(pal_we), 0);
    chk("R1", "mem_rready", 32'(mem_rready), 0);
    chk("R1", "desc_ready", 32'(desc_ready), 1);

    // sweep: palette on channel 0 over all depths and several lengths
    hs_rand = 1'b1;
    for (int d = 0; d < 4; d++) begin
      for (int li = 0; li < 4; li++) begin
        int pb, pw, len;
        bit sof, eof;
        logic [31:0] cmd;
        len = lens[li];
        pb  = (d == 3) ? 512 : (d == 2) ? 32 : 8;
        pw  = ((len < pb) ? len : pb) / 4;
        sof = li[0];
        eof = li[1] ^ d[0];
        cmd = mk_cmd(1'b1, sof, eof, len);
        set_exp(0, 32'h1000_0000 + 32'(d * 32'h1_0000 + li * 32'h1000), len, pw);
        pix_depth = 2'(d);
        send_desc(0, cmd | JUNK, base_e[0]);
        pix_depth = ~2'(d);  // R5: depth is sampled only at load
        #9;
        chk("R6", "start-of-frame bit", 32'(stat[0]), 32'(sof));
        chk("R2", "command register ch0", cmd_regs[31:0], cmd);
        wait_done(0);
        chk("R7", "end-of-frame bit", 32'(stat[2]), 32'(eof));
        clear_stat();
      end
    end

    // channel 1 without palette
    for (int li = 0; li < 3; li++) begin
      logic [31:0] cmd;
      cmd = mk_cmd(1'b0, 1'b1, li[0], chl[li]);
      set_exp(1, 32'h2000_0000 + 32'(li * 32'h100), chl[li], 0);
      send_desc(1, cmd | JUNK, base_e[1]);
      #9;
      chk("R6", "start-of-frame bit ch1", 32'(stat[1]), 1);
      chk("R2", "command register ch1", cmd_regs[63:32], cmd);
      wait_done(1);
      chk("R7", "end-of-frame bit ch1", 32'(stat[3]), 32'(li[0]));
      clear_stat();
    end

    // R9: palette words flow while the pixel sink stalls
    hs_rand = 1'b0; fix_rv = 1'b1; fix_pr = 1'b0;
    repeat (2) @(negedge clk);
    pix_depth = 2'd2;
    set_exp(0, 32'h3000_0000, 64, 8);
    send_desc(0, mk_cmd(1'b1, 1'b0, 1'b0, 64), base_e[0]);
    repeat (20) @(negedge clk);
    #9;
    chk("R9", "palette words under stall", 32'(mon_pal[0] - snap_pal[0]), 8);
    chk("R9", "no pixel words under stall", 32'(mon_pix[0] - snap_pix[0]), 0);
    chk("R9", "mem_rready under stall", 32'(mem_rready), 0);
    fix_pr = 1'b1;
    wait_done(0);
    clear_stat();

    // R3 and R10: load both with memory stalled, channel 1 first
    fix_rv = 1'b0; fix_pr = 1'b1;
    repeat (2) @(negedge clk);
    set_exp(1, 32'h4000_0000, 16, 0);
    send_desc(1, mk_cmd(1'b0, 1'b0, 1'b0, 16), base_e[1]);
    set_exp(0, 32'h5000_0000, 16, 0);
    send_desc(0, mk_cmd(1'b0, 1'b0, 1'b0, 16), base_e[0]);
    prev = cmd_regs[31:0];
    @(negedge clk);
    desc_valid = 1'b1; desc_chan = 1'b0; desc_cmd = mk_cmd(1'b0, 1'b1, 1'b1, 40);
    desc_addr = 32'h6000_0000;
    #9;
    chk("R3", "desc_ready while busy", 32'(desc_ready), 0);
    @(negedge clk);
    desc_valid = 1'b0;
    #9;
    chk("R3", "command register unchanged", cmd_regs[31:0], prev);
    chk("R3", "no status from refused descriptor", 32'(stat), 0);
    begin
      int base_seq;
      base_seq = mon_pix[0] + mon_pix[1];
      fix_rv = 1'b1;
      wait_done(0);
      wait_done(1);
      for (int k = 0; k < 8; k++)
        chk("R10", "channel order", 32'(seq_log[(base_seq + k) & 15]), (k < 4) ? 0 : 1);
    end
    clear_stat();

    // R8: illegal descriptors
    fix_rv = 1'b1; fix_pr = 1'b1;
    set_exp(0, 32'h7000_0000, 0, 0);
    send_desc(0, mk_cmd(1'b0, 1'b1, 1'b1, 0), base_e[0]);
    #9;
    chk("R8", "zero length error bit", 32'(stat), 32'h10);
    chk("R8", "ch0 idle after error", 32'(desc_ready), 1);
    chk("R8", "no fetch after error", 32'(mem_rready), 0);
    clear_stat();
    set_exp(1, 32'h7100_0000, 0, 0);
    send_desc(1, mk_cmd(1'b0, 1'b1, 1'b0, 6), base_e[1]);
    #9;
    chk("R8", "misaligned length error bit", 32'(stat), 32'h20);
    clear_stat();
    send_desc(1, mk_cmd(1'b1, 1'b1, 1'b0, 8), base_e[1]);
    #9;
    chk("R8", "palette on ch1 error bit", 32'(stat), 32'h20);
    chk("R8", "ch1 idle after error", 32'(desc_ready), 1);
    repeat (5) @(negedge clk);
    #9;
    chk("R8", "no words from illegal descriptors",
        32'((mon_pix[0] - snap_pix[0]) + (mon_pix[1] - snap_pix[1])), 0);
    clear_stat();

    // R11: sticky flags and selective write-one-to-clear
    set_exp(0, 32'h8000_0000, 4, 0);
    send_desc(0, mk_cmd(1'b0, 1'b1, 1'b0, 4), base_e[0]);
    wait_done(0);
    set_exp(1, 32'h8100_0000, 4, 0);
    send_desc(1, mk_cmd(1'b0, 1'b1, 1'b1, 4), base_e[1]);
    wait_done(1);
    repeat (5) @(negedge clk);
    #9;
    chk("R11", "flags held", 32'(stat), 32'h0B);
    @(negedge clk); stat_clr = 6'h01;
    @(negedge clk); stat_clr = '0;
    #9;
    chk("R11", "only written bit cleared", 32'(stat), 32'h0A);
    set_exp(0, 32'h8200_0000, 4, 0);
    @(negedge clk);
    desc_valid = 1'b1; desc_chan = 1'b0; desc_cmd = mk_cmd(1'b0, 1'b1, 1'b0, 4);
    desc_addr = base_e[0]; stat_clr = 6'h01;
    #9;
    chk("R11", "desc_ready for same-cycle test", 32'(desc_ready), 1);
    @(negedge clk);
    desc_valid = 1'b0; stat_clr = '0;
    #9;
    chk("R11", "set wins over clear", 32'(stat[0]), 1);
    wait_done(0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors",
             checks + mon_checks, errors + mon_errors);
    $finish;
  end
endmodule